// File: doc/BRIEF.md
# Two-Lane Double-Edge Write Frame Serializer

This block sits on the host side of a narrow serial display link. It takes a single write cycle from an i80-style parallel CPU bus and sends it out as a short burst on two serial data lanes. The burst comes with a forwarded link clock, and a bit moves on every edge of that clock. The inputs are a 16-bit data word, an address/data flag, two active-low chip selects and an active-low write strobe. Each burst is ten bits per lane. The first two bits on each lane are control bits: a Low start marker, the address/data flag, a write marker and a chip-select selector. The two payload bytes follow, least significant bit first.

The block runs from one fast clock. Each tick of that clock stands for one half-period of the link clock. The link clock toggles on every tick, and it is forced High on the first tick of each frame, so the two control bits fall in the first whole link-clock cycle. Between frames both lanes rest High.

An active-low power-down request parks the link in an OFF state, in which the lanes, the clock and the drive enable are all Low. The block honours the request only after the link has been idle long enough for the far side to finish a write in progress. A host with an 8-bit or 9-bit bus ties the unused data inputs to constants, and the frame layout stays the same.

Top module: `ddr_write_tx`

## Requirements
- R1: A sampled write starts a frame on the next tick. The frame lasts exactly 10 ticks, during which busy is High. linkClk is High on the first tick and toggles on every tick, giving the pattern 1,0,1,0,... over ticks 0 to 9.
- R2: lane0 carries, over ticks 0 to 9: 0 (start marker), then addrData, then dataIn[0] through dataIn[7].
- R3: lane1 carries, over ticks 0 to 9: 0 (write marker), then the selector bit, then dataIn[8] through dataIn[15].
- R4: The selector bit is 1 when csN1 is Low and csN2 is High. It is 0 when csN2 is Low and csN1 is High.
- R5: A write strobe with both chip selects Low, or with both High, produces no frame. busy stays Low and the lanes stay High.
- R6: Out of reset, and between frames while the link is powered, drvEn is 1, both lanes are High and linkClk toggles on every tick.
- R7: A write strobe that arrives while busy is High is ignored. The current frame is neither altered nor extended, and no frame follows it.
- R8: While pdN is held Low, drvEn falls exactly after 41 idle ticks (2 x IDLE_CYCLES + 1). These are counted from the first tick on which busy is Low after a frame.
- R9: In the OFF state, drvEn, lane0, lane1 and linkClk are all 0, and write strobes are ignored.
- R10: When pdN returns High, the next tick shows drvEn at 1 with both lanes High, and a later write produces a normal frame.
- R11: If a legal write and an eligible power-down arrive on the same tick, the write wins. The frame is sent, and the OFF state comes only after a fresh 41-tick idle window.
- R12: With the upper data inputs tied to 0, as for an 8-bit or 9-bit host, the frame keeps the same 10-bit layout and those payload bits are sent as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast clock; one tick per link-clock edge |
| rstN | input | 1 | Asynchronous active-low reset |
| wrN | input | 1 | Active-low write strobe, sampled each tick |
| csN1 | input | 1 | Active-low chip select 1 |
| csN2 | input | 1 | Active-low chip select 2 |
| addrData | input | 1 | Address/data flag sent in the control slot |
| dataIn | input | 16 | Write data; low byte on lane0, high byte on lane1 |
| pdN | input | 1 | Active-low power-down request |
| lane0 | output | 1 | Serial lane 0 |
| lane1 | output | 1 | Serial lane 1 |
| linkClk | output | 1 | Forwarded link clock |
| drvEn | output | 1 | Line drive enable; 0 in the OFF state |
| busy | output | 1 | High while a frame is being sent |

## Verification
A write acceptance and a power-down entry can fall on the same tick. This happens once the idle count has reached its limit with pdN Low and a legal write strobe arrives on that very tick. The bench lets the link sit idle well past the window and then lowers pdN and wrN together on one tick. It then expects a complete, correct frame with drvEn held High throughout, followed by exactly 41 powered idle ticks before drvEn drops. Any early OFF entry, lost frame or short idle window is reported against R11.

// File: rtl/ddr_write_tx_pkg.sv
package ddr_write_tx_pkg;

  // Strobes the control unit issues to the datapath each tick
  typedef struct packed {
    logic load;   // capture a new write and emit control tick 0
    logic shift;  // advance both lanes by one bit
    logic goOff;  // enter the unpowered OFF state
    logic wake;   // leave the OFF state
  } txStrobeT;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FRAME = 2'd1,
    ST_OFF   = 2'd2
  } txStateT;

endpackage

// File: rtl/ddr_write_tx_ctrl.sv
module ddr_write_tx_ctrl
  import ddr_write_tx_pkg::*;
#(
  parameter int LANE_BITS   = 10,
  parameter int IDLE_CYCLES = 20
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     wrN,
  input  logic     csN1,
  input  logic     csN2,
  input  logic     pdN,
  output txStrobeT strb,
  output logic     busy
);

  localparam int IDLE_TICKS = 2 * IDLE_CYCLES;
  localparam int CW = $clog2(IDLE_TICKS + 1);
  localparam int IW = $clog2(LANE_BITS);
  localparam logic [CW-1:0] IDLE_MAX = CW'(IDLE_TICKS);
  localparam logic [IW-1:0] LAST_IDX = IW'(LANE_BITS - 1);

  txStateT       state;
  logic [IW-1:0] idx;
  logic [CW-1:0] idleCnt;
  logic          accept;
  logic          csLegal;

  // exactly one chip select must be asserted
  assign csLegal = csN1 ^ csN2;
  assign accept  = (state == ST_IDLE) && !wrN && csLegal;

  always_comb begin
    strb       = '0;
    strb.load  = accept;
    strb.shift = (state == ST_FRAME);
    // a write on the same tick takes priority over power-down
    strb.goOff = (state == ST_IDLE) && !accept && !pdN && (idleCnt == IDLE_MAX);
    strb.wake  = (state == ST_OFF) && pdN;
  end

  assign busy = (state == ST_FRAME);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      idx   <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (accept) begin
            state <= ST_FRAME;
            idx   <= '0;
          end else if (strb.goOff) begin
            state <= ST_OFF;
          end
        end
        ST_FRAME: begin
          if (idx == LAST_IDX) begin
            state <= ST_IDLE;
            idx   <= '0;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        ST_OFF: begin
          if (strb.wake) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // Idle tick counter: cleared by frames and wake-up, saturates at the window
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idleCnt <= '0;
    end else if ((state == ST_FRAME) || accept || strb.wake) begin
      idleCnt <= '0;
    end else if ((state == ST_IDLE) && (idleCnt != IDLE_MAX)) begin
      idleCnt <= idleCnt + 1'b1;
    end
  end

  // R1: the frame ends right after its last tick
  p_frame_len_r1: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_FRAME && idx == LAST_IDX) |=> (state == ST_IDLE));

  // R7: inside a frame the bit index only advances by one
  p_busy_ignore_r7: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_FRAME && idx != LAST_IDX) |=> (state == ST_FRAME && idx == $past(idx) + 1'b1));

  // R5: illegal chip-select pairs never start a frame
  p_illegal_cs_r5: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && !wrN && (csN1 == csN2)) |=> (state != ST_FRAME));

  // R8: the OFF state is entered only after a full idle window with a request
  p_off_wait_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(state == ST_OFF) |-> ($past(idleCnt) == IDLE_MAX && $past(!pdN)));

endmodule

// File: rtl/ddr_write_tx_dp.sv
module ddr_write_tx_dp
  import ddr_write_tx_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  txStrobeT          strb,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              addrData,
  input  logic              csN1,
  output logic              lane0,
  output logic              lane1,
  output logic              linkClk,
  output logic              drvEn
);

  localparam int HALF      = DATA_W / 2;
  localparam int LANE_BITS = HALF + 2;

  logic [LANE_BITS-1:0] word0, word1;
  logic [LANE_BITS-2:0] sh0, sh1;
  logic                 lane0Q, lane1Q, clkQ, drvEnQ;
  logic                 csSel;

  assign csSel = !csN1;

  // bit 0 leaves first: control pair, then the payload LSB first
  assign word0 = {dataIn[HALF-1:0], addrData, 1'b0};
  assign word1 = {dataIn[DATA_W-1:HALF], csSel, 1'b0};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sh0    <= '1;
      sh1    <= '1;
      lane0Q <= 1'b1;
      lane1Q <= 1'b1;
      clkQ   <= 1'b0;
      drvEnQ <= 1'b1;
    end else if (strb.goOff) begin
      sh0    <= '1;
      sh1    <= '1;
      lane0Q <= 1'b0;
      lane1Q <= 1'b0;
      clkQ   <= 1'b0;
      drvEnQ <= 1'b0;
    end else if (strb.wake) begin
      lane0Q <= 1'b1;
      lane1Q <= 1'b1;
      clkQ   <= 1'b0;
      drvEnQ <= 1'b1;
    end else if (strb.load) begin
      lane0Q <= word0[0];
      lane1Q <= word1[0];
      sh0    <= word0[LANE_BITS-1:1];
      sh1    <= word1[LANE_BITS-1:1];
      clkQ   <= 1'b1;
    end else begin
      if (strb.shift) begin
        // idle level fills in behind the payload
        lane0Q <= sh0[0];
        lane1Q <= sh1[0];
        sh0    <= {1'b1, sh0[LANE_BITS-2:1]};
        sh1    <= {1'b1, sh1[LANE_BITS-2:1]};
      end
      if (drvEnQ) clkQ <= ~clkQ;
    end
  end

  assign lane0   = lane0Q;
  assign lane1   = lane1Q;
  assign linkClk = clkQ;
  assign drvEn   = drvEnQ;

endmodule

// File: rtl/ddr_write_tx.sv
module ddr_write_tx
  import ddr_write_tx_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int IDLE_CYCLES = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrN,
  input  logic              csN1,
  input  logic              csN2,
  input  logic              addrData,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              pdN,
  output logic              lane0,
  output logic              lane1,
  output logic              linkClk,
  output logic              drvEn,
  output logic              busy
);

  localparam int LANE_BITS = DATA_W / 2 + 2;

  txStrobeT strb;

  ddr_write_tx_ctrl #(
    .LANE_BITS  (LANE_BITS),
    .IDLE_CYCLES(IDLE_CYCLES)
  ) u_ctrl (
    .clk (clk),
    .rstN(rstN),
    .wrN (wrN),
    .csN1(csN1),
    .csN2(csN2),
    .pdN (pdN),
    .strb(strb),
    .busy(busy)
  );

  ddr_write_tx_dp #(
    .DATA_W(DATA_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .dataIn  (dataIn),
    .addrData(addrData),
    .csN1    (csN1),
    .lane0   (lane0),
    .lane1   (lane1),
    .linkClk (linkClk),
    .drvEn   (drvEn)
  );

  // R2/R3: the first frame tick carries the Low start and write markers
  p_start_bits_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> (!lane0 && !lane1));

  // R1: the link clock is High on the first frame tick
  p_frame_clk_r1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> linkClk);

  // R1: the link clock toggles on every tick inside a frame
  p_clk_toggle_r1: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> (linkClk != $past(linkClk)));

  // R6: the lanes rest High between frames while powered
  p_idle_high_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && $past(!busy) && drvEn) |-> (lane0 && lane1));

  // R9: nothing is driven in the OFF state
  p_off_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    !drvEn |-> (!lane0 && !lane1 && !linkClk && !busy));

endmodule

// File: tb/ddr_write_tx_test.sv
module ddr_write_tx_test;

  localparam int CLK_PERIOD = 10;
  localparam int LB         = 10;
  localparam int OFF_WAIT   = 41;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrN = 1'b1;
  logic        csN1 = 1'b1;
  logic        csN2 = 1'b1;
  logic        addrData = 1'b0;
  logic [15:0] dataIn = '0;
  logic        pdN = 1'b1;
  logic        lane0, lane1, linkClk, drvEn, busy;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  typedef struct {
    logic [9:0] e0;
    logic [9:0] e1;
    string      tag;
  } expT;

  expT expQ[$];

  ddr_write_tx uut (
    .clk(clk), .rstN(rstN), .wrN(wrN), .csN1(csN1), .csN2(csN2),
    .addrData(addrData), .dataIn(dataIn), .pdN(pdN),
    .lane0(lane0), .lane1(lane1), .linkClk(linkClk), .drvEn(drvEn), .busy(busy)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic sample();
    @(posedge clk);
    #1;
  endtask

  // Driver: one write strobe tick; pushes the expected frame when legal
  task automatic sendWrite(input logic [15:0] d, input logic ad, input logic c1,
                           input logic c2, input bit expectFrame, input string tag);
    expT e;
    @(negedge clk);
    if (expectFrame) begin
      e.e0  = {d[7:0], ad, 1'b0};
      e.e1  = {d[15:8], ~c1, 1'b0};
      e.tag = tag;
      expQ.push_back(e);
    end
    dataIn = d; addrData = ad; csN1 = c1; csN2 = c2; wrN = 1'b0;
    @(negedge clk);
    wrN = 1'b1; csN1 = 1'b1; csN2 = 1'b1;
  endtask

  task automatic waitIdle();
    sample();
    while (busy) sample();
    repeat (2) sample();
  endtask

  // counts powered idle ticks after a frame until drvEn drops
  task automatic countToOff(output int n);
    n = 0;
    sample();
    while (busy) sample();
    while (drvEn && n < 200) begin
      n++;
      sample();
    end
  endtask

  task automatic checkNoFrame(input int ticks, input string req);
    int seen = 0;
    for (int i = 0; i < ticks; i++) begin
      sample();
      if (busy) seen++;
    end
    check(seen == 0, req, "busy ticks with no frame expected", seen, 0);
  endtask

  // Monitor / scoreboard
  initial begin : monitor
    int k;
    bit inFrame;
    bit prevBusy;
    logic [9:0] a0, a1, ac, ab;
    expT cur;
    inFrame = 0; prevBusy = 0; k = 0;
    a0 = '0; a1 = '0; ac = '0; ab = '0;
    forever begin
      sample();
      if (!rstN) begin
        inFrame = 0; prevBusy = 0;
      end else begin
        if (inFrame && k == LB) begin
          inFrame = 0;
          check(a0 == cur.e0, "R2", {"lane0 bits ", cur.tag}, a0, cur.e0);
          check(a1 == cur.e1, cur.tag, "lane1 bits", a1, cur.e1);
          check(ac == 10'h155 && ab == 10'h3FF, "R1", "clock/busy pattern",
                {ab, ac}, {10'h3FF, 10'h155});
          check(!busy && lane0 && lane1, "R6", "idle after frame {busy,l0,l1}",
                {busy, lane0, lane1}, 3'b011);
        end
        if (!inFrame && busy && !prevBusy) begin
          if (expQ.size() == 0) begin
            check(0, "R5 R7 R9", "unexpected frame", 1, 0);
          end else begin
            cur = expQ.pop_front();
            inFrame = 1;
            k = 0;
          end
        end
        if (inFrame && k < LB) begin
          a0[k] = lane0; a1[k] = lane1; ac[k] = linkClk; ab[k] = busy;
          k++;
        end
        prevBusy = busy;
      end
    end
  end

  initial begin : watchdog
    #(CLK_PERIOD * 50000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : stimulus
    int n;
    int toggles;
    logic prevClk;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    sample();
    // R6: reset state
    check(!busy && drvEn && lane0 && lane1, "R6", "reset {busy,drvEn,l0,l1}",
          {busy, drvEn, lane0, lane1}, 4'b0111);
    toggles = 0;
    prevClk = linkClk;
    for (int i = 0; i < 5; i++) begin
      sample();
      if (linkClk != prevClk) toggles++;
      prevClk = linkClk;
    end
    check(toggles == 5, "R6", "idle clock toggles", toggles, 5);

    // R2 R3 R4: several legal writes
    sendWrite(16'hA5C3, 1'b1, 1'b0, 1'b1, 1, "R3 R4 cs1");
    waitIdle();
    sendWrite(16'h3C5A, 1'b0, 1'b1, 1'b0, 1, "R3 R4 cs2");
    waitIdle();
    sendWrite(16'hFFFF, 1'b0, 1'b0, 1'b1, 1, "R3 R4 ones");
    waitIdle();
    sendWrite(16'h8001, 1'b1, 1'b1, 1'b0, 1, "R3 R4 edges");
    waitIdle();

    // R12: narrow host buses with tied upper inputs
    sendWrite(16'h00B7, 1'b1, 1'b0, 1'b1, 1, "R12 8-bit");
    waitIdle();
    sendWrite(16'h0155, 1'b0, 1'b1, 1'b0, 1, "R12 9-bit");
    waitIdle();

    // R5: illegal chip-select pairs
    sendWrite(16'h1234, 1'b1, 1'b0, 1'b0, 0, "");
    checkNoFrame(14, "R5 both low");
    sendWrite(16'h4321, 1'b0, 1'b1, 1'b1, 0, "");
    checkNoFrame(14, "R5 none");
    check(lane0 && lane1, "R5", "lanes after rejected writes", {lane0, lane1}, 2'b11);

    // R7: write during a frame is ignored
    sendWrite(16'h6B2D, 1'b1, 1'b0, 1'b1, 1, "R3 R7 kept");
    repeat (3) @(negedge clk);
    sendWrite(16'hFFFF, 1'b0, 1'b1, 1'b0, 0, "");
    waitIdle();
    checkNoFrame(12, "R7");

    // R8: power-down after the idle window
    sendWrite(16'h0F0F, 1'b0, 1'b0, 1'b1, 1, "R3 R8");
    repeat (4) @(negedge clk);
    pdN = 1'b0;
    countToOff(n);
    check(n == OFF_WAIT, "R8", "powered idle ticks before OFF", n, OFF_WAIT);

    // R9: OFF state is quiet and ignores writes
    check({drvEn, lane0, lane1, linkClk} == 4'b0000, "R9", "OFF outputs",
          {drvEn, lane0, lane1, linkClk}, 0);
    sendWrite(16'h5555, 1'b1, 1'b0, 1'b1, 0, "");
    checkNoFrame(10, "R9");
    check({drvEn, lane0, lane1, linkClk} == 4'b0000, "R9", "OFF after write",
          {drvEn, lane0, lane1, linkClk}, 0);

    // R10: wake up
    @(negedge clk);
    pdN = 1'b1;
    sample();
    check(drvEn && lane0 && lane1 && !busy, "R10", "wake {drvEn,l0,l1,busy}",
          {drvEn, lane0, lane1, busy}, 4'b1110);
    repeat (2) sample();
    sendWrite(16'hC0DE, 1'b1, 1'b1, 1'b0, 1, "R3 R10");
    waitIdle();

    // R11: write and eligible power-down on the same tick
    repeat (50) sample();
    begin
      expT e;
      @(negedge clk);
      e.e0 = {8'hE1, 1'b1, 1'b0};
      e.e1 = {8'h7A, 1'b1, 1'b0};
      e.tag = "R3 R11";
      expQ.push_back(e);
      dataIn = 16'h7AE1; addrData = 1'b1; csN1 = 1'b0; csN2 = 1'b1;
      wrN = 1'b0; pdN = 1'b0;
      @(negedge clk);
      wrN = 1'b1; csN1 = 1'b1; csN2 = 1'b1;
    end
    #1;
    check(busy && drvEn, "R11", "write wins {busy,drvEn}", {busy, drvEn}, 2'b11);
    countToOff(n);
    check(n == OFF_WAIT, "R11", "fresh idle window after frame", n, OFF_WAIT);
    check(expQ.size() == 0, "R11", "frames left unsent", expQ.size(), 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule